// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the combinational arithmetic and logic stage of a small RISC core. Each cycle the core hands it a first register operand, a second operand taken either from a register or from an immediate field, a 5-bit operation code and the current status flags. The block returns the result byte and a flag vector. A per-flag write mask and a result write enable tell the core which state to commit.

The operations are: add and subtract with and without carry, compare with and without carry, the bitwise operations, one's and two's complement, increment and decrement, the shifts and rotates, and the nibble exchange. The datapath width is a parameter with a default of 8. A flag that an operation does not define keeps its incoming value on `flags_o`, and its bit in `flag_we_o` stays low.

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry-in from flag C) produce the modulo-256 sum. They write C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (bit 7), Z (result zero) and S.
- R2: Codes 2 (subtract), 3 (subtract with borrow), 4 (compare) and 5 (compare with borrow) form the first operand minus the second. They write C (borrow out of bit 7), H (borrow from bit 4), V, N, Z and S. For codes 4 and 5, `result_we_o` is 0 and `result_o` still shows the difference.
- R3: For codes 3 and 5, Z becomes 1 only when the difference is zero and the incoming Z is 1. Otherwise Z becomes 0.
- R4: Codes 6 (AND), 7 (OR) and 8 (XOR) write only Z, N, V and S, with V cleared. Code 9 ANDs the first operand with the bitwise inverse of the second and updates the same flags. C and H keep their input values.
- R5: Code 10 returns 0xFF minus the first operand. It sets C to 1, clears V and writes Z, N and S.
- R6: Code 11 returns 0x00 minus the first operand. C is 1 unless the operand is zero, V is 1 only for an operand of 0x80, and H is the borrow from bit 4. Z, N and S are also written.
- R7: Code 12 adds one and code 13 subtracts one. Only Z, N, V and S are written, so C and H keep their input values. V is set when increment gives 0x80 or decrement gives 0x7F.
- R8: Codes 14 (shift left, 0 into bit 0), 15 (shift right, 0 into bit 7), 16 (rotate left through C) and 17 (rotate right through C) set C to the bit shifted out. They write Z, N, S and V, with V equal to N XOR C of the new values.
- R9: Code 18 shifts right arithmetically. Bit 7 is kept, bits 7..1 move into bits 6..0, and bit 0 goes to C. It writes the same flags as R8.
- R10: Code 19 exchanges the upper and lower nibbles, writes the result and writes no flag.
- R11: The flag vector is laid out as C bit 0, Z bit 1, N bit 2, V bit 3, S bit 4, H bit 5, T bit 6. S always equals N XOR V when written. Every bit not set in `flag_we_o` equals the same bit of `flags_i`, and T is never written.
- R12: When `use_imm_i` is 1, `imm_i` replaces `opb_i` as the second operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see requirements) |
| opa_i | input | 8 | First operand, also the single operand of unary operations |
| opb_i | input | 8 | Second register operand |
| imm_i | input | 8 | Immediate second operand |
| use_imm_i | input | 1 | Select immediate as second operand |
| flags_i | input | 7 | Current status flags |
| result_o | output | 8 | Result byte |
| result_we_o | output | 1 | Result should be written back |
| flags_o | output | 7 | Updated flags; unwritten bits pass through |
| flag_we_o | output | 7 | Per-flag write mask |

## Verification
The checker relies on the inputs being fully known: it checks nothing while any operation code or flag input bit is unknown. It also assumes that codes 20 to 31 are never issued, because no property pins down their outputs. The bench drives every input to a known value before each comparison and draws its random codes only from 0 to 19. That stimulus covers all flag input patterns, so the chained zero rule and the carry-in paths are seen with both incoming values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int FLAG_CNT = 7;
   localparam int OP_W     = 5;

   localparam int FC = 0;
   localparam int FZ = 1;
   localparam int FN = 2;
   localparam int FV = 3;
   localparam int FS = 4;
   localparam int FH = 5;
   localparam int FT = 6;

   typedef logic [FLAG_CNT-1:0] flag_vec_t;

   localparam flag_vec_t MASK_FULL  = flag_vec_t'(7'b011_1111);
   localparam flag_vec_t MASK_ZCNVS = flag_vec_t'(7'b001_1111);
   localparam flag_vec_t MASK_ZNVS  = flag_vec_t'(7'b001_1110);

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_CP   = 5'd4,
      OP_CPC  = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_CBR  = 5'd9,
      OP_COM  = 5'd10,
      OP_NEG  = 5'd11,
      OP_INC  = 5'd12,
      OP_DEC  = 5'd13,
      OP_LSL  = 5'd14,
      OP_LSR  = 5'd15,
      OP_ROL  = 5'd16,
      OP_ROR  = 5'd17,
      OP_ASR  = 5'd18,
      OP_SWAP = 5'd19
   } alu_op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_NOT = 2'd3
   } logic_sel_e;

   typedef enum logic [2:0] {
      SH_LSL  = 3'd0,
      SH_LSR  = 3'd1,
      SH_ROL  = 3'd2,
      SH_ROR  = 3'd3,
      SH_ASR  = 3'd4,
      SH_SWAP = 3'd5
   } shift_sel_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
   parameter int DATA_W = 8,
   parameter int HALF_BIT = 3
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] r_o,
   output logic              c_o,
   output logic              h_o,
   output logic              v_o
);
   localparam int MSB = DATA_W - 1;
   localparam int LOW_W = HALF_BIT + 1;

   logic [DATA_W:0] full;
   logic [LOW_W:0]  low;

   always_comb begin
      if (sub_i) begin
         full = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
         low  = {1'b0, a_i[HALF_BIT:0]} - {1'b0, b_i[HALF_BIT:0]} - {{LOW_W{1'b0}}, cin_i};
      end else begin
         full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
         low  = {1'b0, a_i[HALF_BIT:0]} + {1'b0, b_i[HALF_BIT:0]} + {{LOW_W{1'b0}}, cin_i};
      end
      r_o = full[MSB:0];
      c_o = full[DATA_W];
      h_o = low[LOW_W];
      if (sub_i)
         v_o = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ full[MSB]);
      else
         v_o = ~(a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ full[MSB]);
   end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic_sel_e        sel_i,
   output logic [DATA_W-1:0] r_o
);
   always_comb begin
      unique case (sel_i)
         LG_AND:  r_o = a_i & b_i;
         LG_OR:   r_o = a_i | b_i;
         LG_XOR:  r_o = a_i ^ b_i;
         default: r_o = ~a_i;
      endcase
   end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              cin_i,
   input  shift_sel_e        sel_i,
   output logic [DATA_W-1:0] r_o,
   output logic              c_o
);
   localparam int MSB  = DATA_W - 1;
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] swapped;

   generate
      for (genvar i = 0; i < HALF; i++) begin : g_swap
         assign swapped[i]        = a_i[i + HALF];
         assign swapped[i + HALF] = a_i[i];
      end
   endgenerate

   always_comb begin
      r_o = a_i;
      c_o = 1'b0;
      case (sel_i)
         SH_LSL:  begin r_o = {a_i[MSB-1:0], 1'b0};     c_o = a_i[MSB]; end
         SH_LSR:  begin r_o = {1'b0, a_i[MSB:1]};       c_o = a_i[0];   end
         SH_ROL:  begin r_o = {a_i[MSB-1:0], cin_i};    c_o = a_i[MSB]; end
         SH_ROR:  begin r_o = {cin_i, a_i[MSB:1]};      c_o = a_i[0];   end
         SH_ASR:  begin r_o = {a_i[MSB], a_i[MSB:1]};   c_o = a_i[0];   end
         SH_SWAP: begin r_o = swapped;                  c_o = 1'b0;     end
         default: begin r_o = a_i;                      c_o = 1'b0;     end
      endcase
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]     op_i,
   input  logic [DATA_W-1:0]   opa_i,
   input  logic [DATA_W-1:0]   opb_i,
   input  logic [DATA_W-1:0]   imm_i,
   input  logic                use_imm_i,
   input  logic [FLAG_CNT-1:0] flags_i,
   output logic [DATA_W-1:0]   result_o,
   output logic                result_we_o,
   output logic [FLAG_CNT-1:0] flags_o,
   output logic [FLAG_CNT-1:0] flag_we_o
);
   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("alu8_core: DATA_W must be even and at least 8");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] ar_a, ar_b, ar_r, lg_b, lg_r, sh_r;
   logic              ar_sub, ar_cin, ar_c, ar_h, ar_v, sh_c;
   logic_sel_e        lg_sel;
   shift_sel_e        sh_sel;

   assign op     = alu_op_e'(op_i);
   assign opnd_b = use_imm_i ? imm_i : opb_i;

   always_comb begin
      ar_a   = opa_i;
      ar_b   = opnd_b;
      ar_sub = 1'b0;
      case (op)
         OP_SUB, OP_SBC, OP_CP, OP_CPC: ar_sub = 1'b1;
         OP_NEG: begin ar_a = '0; ar_b = opa_i; ar_sub = 1'b1; end
         OP_INC: ar_b = ONE;
         OP_DEC: begin ar_b = ONE; ar_sub = 1'b1; end
         default: ;
      endcase
      ar_cin = (op inside {OP_ADC, OP_SBC, OP_CPC}) & flags_i[FC];
   end

   always_comb begin
      lg_b = (op == OP_CBR) ? ~opnd_b : opnd_b;
      case (op)
         OP_OR:   lg_sel = LG_OR;
         OP_XOR:  lg_sel = LG_XOR;
         OP_COM:  lg_sel = LG_NOT;
         default: lg_sel = LG_AND;
      endcase
      case (op)
         OP_LSR:  sh_sel = SH_LSR;
         OP_ROL:  sh_sel = SH_ROL;
         OP_ROR:  sh_sel = SH_ROR;
         OP_ASR:  sh_sel = SH_ASR;
         OP_SWAP: sh_sel = SH_SWAP;
         default: sh_sel = SH_LSL;
      endcase
   end

   alu8_arith #(.DATA_W(DATA_W)) u_arith (
      .a_i(ar_a), .b_i(ar_b), .cin_i(ar_cin), .sub_i(ar_sub),
      .r_o(ar_r), .c_o(ar_c), .h_o(ar_h), .v_o(ar_v)
   );

   alu8_logic #(.DATA_W(DATA_W)) u_logic (
      .a_i(opa_i), .b_i(lg_b), .sel_i(lg_sel), .r_o(lg_r)
   );

   alu8_shift #(.DATA_W(DATA_W)) u_shift (
      .a_i(opa_i), .cin_i(flags_i[FC]), .sel_i(sh_sel), .r_o(sh_r), .c_o(sh_c)
   );

   logic [DATA_W-1:0] res;
   logic              res_we, nc, nh, nv, nz, nn, zchain;
   flag_vec_t         we, nf;

   always_comb begin
      res    = opa_i;
      res_we = 1'b0;
      we     = '0;
      nc     = flags_i[FC];
      nh     = flags_i[FH];
      nv     = flags_i[FV];
      zchain = 1'b0;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
            res = ar_r; res_we = 1'b1; we = MASK_FULL;
            nc = ar_c; nh = ar_h; nv = ar_v; zchain = (op == OP_SBC);
         end
         OP_CP, OP_CPC: begin
            res = ar_r; we = MASK_FULL;
            nc = ar_c; nh = ar_h; nv = ar_v; zchain = (op == OP_CPC);
         end
         OP_AND, OP_OR, OP_XOR, OP_CBR: begin
            res = lg_r; res_we = 1'b1; we = MASK_ZNVS; nv = 1'b0;
         end
         OP_COM: begin
            res = lg_r; res_we = 1'b1; we = MASK_ZCNVS; nc = 1'b1; nv = 1'b0;
         end
         OP_INC, OP_DEC: begin
            res = ar_r; res_we = 1'b1; we = MASK_ZNVS; nv = ar_v;
         end
         OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
            res = sh_r; res_we = 1'b1; we = MASK_ZCNVS;
            nc = sh_c; nv = sh_r[MSB] ^ sh_c;
         end
         OP_SWAP: begin
            res = sh_r; res_we = 1'b1;
         end
         default: ;
      endcase
      nn = res[MSB];
      nz = (res == '0) & (~zchain | flags_i[FZ]);
      nf = '0;
      nf[FC] = nc;
      nf[FZ] = nz;
      nf[FN] = nn;
      nf[FV] = nv;
      nf[FS] = nn ^ nv;
      nf[FH] = nh;
   end

   assign result_o    = res;
   assign result_we_o = res_we;
   assign flag_we_o   = we;
   assign flags_o     = (nf & we) | (flags_i & ~we);

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
(
   input logic [OP_W-1:0]     op_i,
   input logic [FLAG_CNT-1:0] flags_i,
   input logic                result_we_o,
   input logic [FLAG_CNT-1:0] flags_o,
   input logic [FLAG_CNT-1:0] flag_we_o
);
   logic known;
   assign known = !$isunknown({op_i, flags_i});

   always_comb begin
      if (known) begin
         assert_sign_rule_R11: assert (!flag_we_o[FS] || (flags_o[FS] == (flags_o[FN] ^ flags_o[FV])))
            else $error("S not N xor V");
         assert_keep_unwritten_R11: assert ((flags_o & ~flag_we_o) == (flags_i & ~flag_we_o))
            else $error("unwritten flag changed");
         assert_t_untouched_R11: assert (!flag_we_o[FT])
            else $error("T written");
         assert_swap_quiet_R10: assert (op_i != OP_SWAP || (flag_we_o == '0 && result_we_o))
            else $error("swap touched flags");
         assert_compare_no_write_R2: assert (!(op_i == OP_CP || op_i == OP_CPC) || !result_we_o)
            else $error("compare wrote result");
         assert_incdec_keep_carry_R7: assert (!(op_i == OP_INC || op_i == OP_DEC)
                                              || (flags_o[FC] == flags_i[FC] && flags_o[FH] == flags_i[FH]))
            else $error("inc/dec changed C or H");
         assert_logic_v_clear_R4: assert (!(op_i inside {OP_AND, OP_OR, OP_XOR, OP_CBR}) || !flags_o[FV])
            else $error("logic left V set");
         assert_shift_v_rule_R8: assert (!(op_i inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR})
                                         || (flags_o[FV] == (flags_o[FN] ^ flags_o[FC])))
            else $error("shift V rule");
         assert_com_carry_R5: assert (op_i != OP_COM || flags_o[FC])
            else $error("complement left C clear");
      end
   end
endmodule

bind alu8_core alu8_core_chk u_chk (
   .op_i(op_i), .flags_i(flags_i), .result_we_o(result_we_o),
   .flags_o(flags_o), .flag_we_o(flag_we_o)
);

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [4:0] op_i;
   logic [7:0] opa_i, opb_i, imm_i;
   logic       use_imm_i;
   logic [6:0] flags_i;
   logic [7:0] result_o;
   logic       result_we_o;
   logic [6:0] flags_o, flag_we_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   alu8_core uut (
      .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
      .use_imm_i(use_imm_i), .flags_i(flags_i), .result_o(result_o),
      .result_we_o(result_we_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
   );

   // Behavioural reference: returns result, result write, full flag vector, mask, tag
   function automatic void model(input int op, input int a, input int b, input int imm,
                                 input int ui, input int fl,
                                 output int r, output int rwe, output int fo,
                                 output int we, output string tag);
      int bb, c, z, cin, s, d, C, Z, N, V, H, nf;
      bit chain;
      bb = ui ? imm : b;
      c = fl & 1; z = (fl >> 1) & 1;
      C = c; H = (fl >> 5) & 1; V = (fl >> 3) & 1;
      rwe = 1; we = 0; r = a; chain = 0; tag = "R10";
      case (op)
         0, 1: begin
            cin = (op == 1) ? c : 0;
            s = a + bb + cin; r = s & 255; C = (s >> 8) & 1;
            H = (((a & 15) + (bb & 15) + cin) >> 4) & 1;
            V = (((a ^ r) & (bb ^ r) & 128) != 0);
            we = 'h3F; tag = "R1";
         end
         2, 3, 4, 5: begin
            cin = (op == 3 || op == 5) ? c : 0;
            d = a - bb - cin; r = d & 255; C = (d < 0);
            H = (((a & 15) - (bb & 15) - cin) < 0);
            V = (((a ^ bb) & (a ^ r) & 128) != 0);
            we = 'h3F; chain = (op == 3 || op == 5);
            rwe = (op < 4); tag = chain ? "R3" : "R2";
         end
         6, 7, 8, 9: begin
            case (op)
               6: r = a & bb;
               7: r = a | bb;
               8: r = a ^ bb;
               default: r = a & (255 - bb);
            endcase
            V = 0; we = 'h1E; tag = "R4";
         end
         10: begin r = 255 - a; C = 1; V = 0; we = 'h1F; tag = "R5"; end
         11: begin
            r = (256 - a) & 255; C = (a != 0); V = (a == 128);
            H = ((a & 15) != 0); we = 'h3F; tag = "R6";
         end
         12: begin r = (a + 1) & 255; V = (r == 128); we = 'h1E; tag = "R7"; end
         13: begin r = (a + 255) & 255; V = (r == 127); we = 'h1E; tag = "R7"; end
         14, 15, 16, 17, 18: begin
            case (op)
               14: begin r = (a << 1) & 255; C = a >> 7; end
               15: begin r = a >> 1; C = a & 1; end
               16: begin r = ((a << 1) & 255) | c; C = a >> 7; end
               17: begin r = (a >> 1) | (c << 7); C = a & 1; end
               default: begin r = (a >> 1) | (a & 128); C = a & 1; end
            endcase
            V = ((r >> 7) & 1) ^ C; we = 'h1F;
            tag = (op == 18) ? "R9" : "R8";
         end
         default: begin r = ((a & 15) << 4) | (a >> 4); tag = "R10"; end
      endcase
      N = (r >> 7) & 1;
      Z = (r == 0) && (!chain || z);
      nf = C | (Z << 1) | (N << 2) | (V << 3) | ((N ^ V) << 4) | (H << 5);
      fo = ((nf & we) | (fl & ~we)) & 127;
      if (ui && op <= 9) tag = {tag, "+R12"};
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic apply(input int op, input int a, input int b, input int imm,
                        input int ui, input int fl);
      int r, rwe, fo, we;
      string tag;
      @(posedge clk);
      op_i = op[4:0]; opa_i = a[7:0]; opb_i = b[7:0]; imm_i = imm[7:0];
      use_imm_i = ui[0]; flags_i = fl[6:0];
      @(negedge clk);
      model(op, a, b, imm, ui, fl, r, rwe, fo, we, tag);
      check(tag, "result", int'(result_o), r);
      check(tag, "result_we", int'(result_we_o), rwe);
      check({tag, "/R11"}, "flags", int'(flags_o), fo);
      check({tag, "/R11"}, "flag_we", int'(flag_we_o), we);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      op_i = '0; opa_i = '0; opb_i = '0; imm_i = '0; use_imm_i = 1'b0; flags_i = '0;
      repeat (2) @(posedge clk);
      // idle inputs: add of zeros gives Z set (R1)
      apply(0, 8'h00, 8'h00, 0, 0, 7'h00);
      // R1 corners: half carry, signed overflow, carry with zero
      apply(0, 8'h0F, 8'h01, 0, 0, 7'h00);
      apply(0, 8'h7F, 8'h01, 0, 0, 7'h00);
      apply(0, 8'hFF, 8'h01, 0, 0, 7'h40);
      apply(1, 8'h10, 8'h20, 0, 0, 7'h01);
      // R2: borrows and overflow, compare does not write
      apply(2, 8'h10, 8'h01, 0, 0, 7'h00);
      apply(2, 8'h00, 8'h01, 0, 0, 7'h00);
      apply(2, 8'h80, 8'h01, 0, 0, 7'h00);
      apply(4, 8'h33, 8'h33, 0, 0, 7'h00);
      // R3: chained zero keeps only an incoming Z
      apply(3, 8'h05, 8'h05, 0, 0, 7'h00);
      apply(3, 8'h05, 8'h05, 0, 0, 7'h02);
      apply(5, 8'h06, 8'h05, 0, 0, 7'h03);
      apply(5, 8'h06, 8'h05, 0, 0, 7'h02);
      // R4: logic with C and H set on input
      apply(6, 8'hF0, 8'h3C, 0, 0, 7'h29);
      apply(7, 8'h00, 8'h00, 0, 0, 7'h21);
      apply(8, 8'hAA, 8'h2A, 0, 0, 7'h08);
      apply(9, 8'hFF, 8'h00, 8'h0F, 1, 7'h21);
      // R5, R6
      apply(10, 8'h00, 0, 0, 0, 7'h00);
      apply(11, 8'h80, 0, 0, 0, 7'h00);
      apply(11, 8'h00, 0, 0, 0, 7'h01);
      apply(11, 8'h01, 0, 0, 0, 7'h00);
      // R7: carry kept
      apply(12, 8'h7F, 0, 0, 0, 7'h21);
      apply(12, 8'hFF, 0, 0, 0, 7'h00);
      apply(13, 8'h80, 0, 0, 0, 7'h01);
      apply(13, 8'h00, 0, 0, 0, 7'h20);
      // R8, R9
      apply(14, 8'h81, 0, 0, 0, 7'h00);
      apply(15, 8'h01, 0, 0, 0, 7'h00);
      apply(16, 8'h40, 0, 0, 0, 7'h01);
      apply(17, 8'h02, 0, 0, 0, 7'h01);
      apply(18, 8'h81, 0, 0, 0, 7'h00);
      // R10
      apply(19, 8'h3C, 0, 0, 0, 7'h55);
      // R12: immediate overrides register operand
      apply(0, 8'h01, 8'h50, 8'h02, 1, 7'h00);
      apply(2, 8'h10, 8'h01, 8'h10, 1, 7'h00);
      // sweep
      for (int i = 0; i < 3000; i++) begin
         apply(int'($urandom_range(19, 0)), int'($urandom_range(255, 0)),
               int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
               int'($urandom_range(1, 0)), int'($urandom_range(127, 0)));
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule